// File: doc/BRIEF.md
# Multi-Mode Timer Counter

This block is a 16-bit timer for a single-clock design. It does not use a divided or switched clock. Instead, one of several clock-enable pulse sources feeds an input divider. The divider produces count ticks, and the counter advances only on those ticks. Software picks one of four counting behaviours: held, counting up to a programmable period, free-running over the full range, or counting up to the period and then back down to zero.

Each time the count completes a cycle, a sticky overflow flag is set. Software clears the flag with a dedicated strobe. While the interrupt enable is set, the flag drives the interrupt request. A one-cycle period-match strobe marks the moment the count reaches the period value, so that capture/compare channels can react to it.

The block is programmed through a few write strobes. One strobe loads the configuration (mode, source, divide code, interrupt enable). Another loads the period. A clear strobe restarts the count and the divider. A flag-clear strobe acknowledges the overflow.

Top module: `mm_timer`

## Requirements
- R1: Mode code 2'b00 holds the count: while in this mode and not cleared, the count does not change whatever the source pulses do.
- R2: Mode code 2'b01 counts 0,1,...,P and then returns to 0, so a period value P gives a repeat length of P+1 ticks.
- R3: In mode 2'b01 and on the upward leg of mode 2'b11, `per_match_o` is high for exactly one cycle, the cycle after the tick that brought the count to P. In mode 2'b01 the overflow flag sets on the tick that returns the count to 0.
- R4: Mode code 2'b10 increments on every tick and wraps from 0xFFFF to 0. The overflow flag sets on that wrap.
- R5: Mode code 2'b11 counts up to P and then down to 0, giving a repeat length of 2×P ticks. The overflow flag sets on the tick that brings the down count to 0.
- R6: Divide code 0,1,2,3 on `cfg_div_i` makes one tick per 1, 2, 4 or 8 pulses of the selected source.
- R7: `cfg_src_i` selects which bit of `src_tick_i` feeds the divider. Pulses on the other bits have no effect on the count.
- R8: A `clr_i` strobe sets the count to 0 and restarts the divider. A full divide interval of source pulses must follow before the next tick.
- R9: The overflow flag stays set until `flag_clr_i` is pulsed. `irq_o` is high exactly when the flag is set and the interrupt enable is 1.
- R10: When an overflow event and `flag_clr_i` fall in the same cycle, the flag ends up set.
- R11: In mode 2'b11, changing P while the count is going down does not stop the descent. The count continues to 0 and sets the flag there.
- R12: In mode 2'b01, writing P below the current count makes the next tick return the count to 0 and set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick_i | input | NSRC | Clock-enable pulse sources |
| cfg_we_i | input | 1 | Write strobe for mode, source, divide and enable |
| cfg_mode_i | input | 2 | Counting mode code |
| cfg_src_i | input | SRC_W | Source index |
| cfg_div_i | input | DIV_W | Divide code (divide by 2^code) |
| cfg_ie_i | input | 1 | Interrupt enable |
| per_we_i | input | 1 | Period write strobe |
| per_i | input | CNT_W | Period value P |
| clr_i | input | 1 | Restart count and divider |
| flag_clr_i | input | 1 | Overflow flag clear strobe |
| count_o | output | CNT_W | Current count |
| per_match_o | output | 1 | One-cycle period-match strobe |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume a few things about the inputs:
- The source index never points past the last implemented source.
- A configuration write does not change the divide code to a nonzero value in the same cycle as a divider tick; otherwise the no-back-to-back-tick property could be stressed.

The stimulus stays within these assumptions. It drives only source indices 0 and 1. It makes every configuration, period and clear write with all sources held low, so no tick falls in a write cycle. Source pulses are only applied between writes.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [1:0] {
        MODE_HOLD = 2'b00,
        MODE_UP   = 2'b01,
        MODE_FREE = 2'b10,
        MODE_UPDN = 2'b11
    } tmr_mode_e;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_i,
    input  logic             clr_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    localparam int CW = (1 << DIV_W) - 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } pre_st_t;

    pre_st_t st_d, st_q;
    logic [CW:0]   one_sh;
    logic [CW-1:0] mask;

    always_comb begin
        one_sh = {{CW{1'b0}}, 1'b1} << div_i;
        mask   = one_sh[CW-1:0] - {{(CW-1){1'b0}}, 1'b1};
        tick_o = src_i && !clr_i && (st_q.cnt == mask);
        st_d   = st_q;
        if (clr_i)       st_d.cnt = '0;
        else if (tick_o) st_d.cnt = '0;
        else if (src_i)  st_d.cnt = st_q.cnt + {{(CW-1){1'b0}}, 1'b1};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6: with a divide above one, two ticks never come back to back
    p_div_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && mask != '0) |=> (!tick_o || mask == '0));
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick_i,
    input  logic      clr_i,
    input  tmr_mode_e mode_i,
    input  logic [W-1:0] per_i,
    output logic [W-1:0] cnt_o,
    output logic      match_o,
    output logic      ovf_o
);
    localparam logic [W-1:0] MAXV = '1;
    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         down;
        logic         match;
    } core_st_t;

    core_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.match = 1'b0;
        ovf_o      = 1'b0;
        if (clr_i) begin
            st_d.cnt  = '0;
            st_d.down = 1'b0;
        end else if (tick_i) begin
            unique case (mode_i)
                MODE_UP: begin
                    st_d.down = 1'b0;
                    if (st_q.cnt >= per_i) begin
                        st_d.cnt = '0;
                        ovf_o    = 1'b1;
                    end else begin
                        st_d.cnt = st_q.cnt + ONE;
                    end
                    st_d.match = (st_d.cnt == per_i);
                end
                MODE_FREE: begin
                    st_d.down = 1'b0;
                    st_d.cnt  = st_q.cnt + ONE;
                    ovf_o     = (st_q.cnt == MAXV);
                end
                MODE_UPDN: begin
                    if (st_q.down || (st_q.cnt >= per_i)) begin
                        if (st_q.cnt != '0) begin
                            st_d.cnt  = st_q.cnt - ONE;
                            st_d.down = (st_q.cnt != ONE);
                            ovf_o     = (st_q.cnt == ONE);
                        end else begin
                            st_d.down = 1'b0;
                        end
                    end else begin
                        st_d.cnt   = st_q.cnt + ONE;
                        st_d.match = (st_d.cnt == per_i);
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o   = st_q.cnt;
    assign match_o = st_q.match;

    // R1: the hold mode freezes the count
    p_hold_frozen_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_HOLD && !clr_i) |=> $stable(cnt_o));
    // R4: free-running mode steps by exactly one per tick
    p_free_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_FREE && tick_i && !clr_i) |=> (cnt_o == W'($past(cnt_o) + ONE)));
endmodule

// File: rtl/mm_timer.sv
module mm_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int NSRC  = 2,
    parameter int DIV_W = 2,
    localparam int SRC_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  src_tick_i,
    input  logic             cfg_we_i,
    input  logic [1:0]       cfg_mode_i,
    input  logic [SRC_W-1:0] cfg_src_i,
    input  logic [DIV_W-1:0] cfg_div_i,
    input  logic             cfg_ie_i,
    input  logic             per_we_i,
    input  logic [CNT_W-1:0] per_i,
    input  logic             clr_i,
    input  logic             flag_clr_i,
    output logic [CNT_W-1:0] count_o,
    output logic             per_match_o,
    output logic             ovf_flag_o,
    output logic             irq_o
);
    typedef struct packed {
        tmr_mode_e        mode;
        logic [SRC_W-1:0] src;
        logic [DIV_W-1:0] div;
        logic             ie;
        logic [CNT_W-1:0] per;
        logic             flag;
    } top_st_t;

    top_st_t st_d, st_q;
    logic    src_sel, tick, ovf_evt;

    always_comb begin
        st_d = st_q;
        if (cfg_we_i) begin
            st_d.mode = tmr_mode_e'(cfg_mode_i);
            st_d.src  = cfg_src_i;
            st_d.div  = cfg_div_i;
            st_d.ie   = cfg_ie_i;
        end
        if (per_we_i)        st_d.per  = per_i;
        if (ovf_evt)         st_d.flag = 1'b1;
        else if (flag_clr_i) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign src_sel = src_tick_i[st_q.src];

    tmr_prescale #(.DIV_W(DIV_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .src_i(src_sel), .clr_i(clr_i),
        .div_i(st_q.div), .tick_o(tick)
    );

    tmr_core #(.W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .clr_i(clr_i),
        .mode_i(st_q.mode), .per_i(st_q.per), .cnt_o(count_o),
        .match_o(per_match_o), .ovf_o(ovf_evt)
    );

    assign ovf_flag_o = st_q.flag;
    assign irq_o      = st_q.flag & st_q.ie;

    // R8: a clear strobe leaves the count at zero
    p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (count_o == '0));
    // R9: the flag only drops on a clear strobe
    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag_o && !flag_clr_i) |=> ovf_flag_o);
    // R10: set beats clear in the same cycle
    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_evt && flag_clr_i) |=> ovf_flag_o);
endmodule

// File: tb/mm_timer_tb.sv
module mm_timer_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  src_tick_i = '0;
    logic        cfg_we_i = 1'b0;
    logic [1:0]  cfg_mode_i = '0;
    logic [0:0]  cfg_src_i = '0;
    logic [1:0]  cfg_div_i = '0;
    logic        cfg_ie_i = 1'b0;
    logic        per_we_i = 1'b0;
    logic [15:0] per_i = '0;
    logic        clr_i = 1'b0;
    logic        flag_clr_i = 1'b0;
    logic [15:0] count_o;
    logic        per_match_o, ovf_flag_o, irq_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    mm_timer dut_i (
        .clk(clk), .rst_n(rst_n), .src_tick_i(src_tick_i), .cfg_we_i(cfg_we_i),
        .cfg_mode_i(cfg_mode_i), .cfg_src_i(cfg_src_i), .cfg_div_i(cfg_div_i),
        .cfg_ie_i(cfg_ie_i), .per_we_i(per_we_i), .per_i(per_i), .clr_i(clr_i),
        .flag_clr_i(flag_clr_i), .count_o(count_o), .per_match_o(per_match_o),
        .ovf_flag_o(ovf_flag_o), .irq_o(irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cfg(logic [1:0] mode, logic src, logic [1:0] dv, logic ie, logic clr);
        @(negedge clk);
        src_tick_i = '0; cfg_we_i = 1'b1; cfg_mode_i = mode; cfg_src_i = src;
        cfg_div_i = dv; cfg_ie_i = ie; clr_i = clr; flag_clr_i = clr;
        @(negedge clk);
        cfg_we_i = 1'b0; clr_i = 1'b0; flag_clr_i = 1'b0;
    endtask

    task automatic set_per(logic [15:0] v);
        @(negedge clk);
        src_tick_i = '0; per_we_i = 1'b1; per_i = v;
        @(negedge clk);
        per_we_i = 1'b0;
    endtask

    // n clock edges with the given source pattern, sampled at the following negedge
    task automatic run(int n, logic [1:0] pat);
        src_tick_i = pat;
        for (int i = 0; i < n; i++) @(negedge clk);
        src_tick_i = '0;
    endtask

    task automatic t_reset();
        chk("R9 reset count", count_o, 0);
        chk("R9 reset flag", ovf_flag_o, 0);
        chk("R9 reset irq", irq_o, 0);
        chk("R3 reset match", per_match_o, 0);
    endtask

    task automatic t_up();
        set_per(16'd3);
        cfg(2'b01, 1'b0, 2'd0, 1'b0, 1'b1);
        run(3, 2'b01);
        chk("R2 up count at P", count_o, 3);
        chk("R3 match at P", per_match_o, 1);
        chk("R3 no flag before return", ovf_flag_o, 0);
        run(1, 2'b01);
        chk("R2 up returns to 0", count_o, 0);
        chk("R3 flag on return", ovf_flag_o, 1);
        chk("R3 match one cycle", per_match_o, 0);
        run(4, 2'b01);
        chk("R2 period P+1", count_o, 0);
    endtask

    task automatic t_free();
        cfg(2'b10, 1'b0, 2'd0, 1'b0, 1'b1);
        run(65535, 2'b01);
        chk("R4 free at max", count_o, 65535);
        chk("R4 no flag before wrap", ovf_flag_o, 0);
        run(1, 2'b01);
        chk("R4 wrap to 0", count_o, 0);
        chk("R4 flag on wrap", ovf_flag_o, 1);
    endtask

    task automatic t_updn();
        set_per(16'd3);
        cfg(2'b11, 1'b0, 2'd0, 1'b0, 1'b1);
        run(3, 2'b01);
        chk("R5 updn top", count_o, 3);
        chk("R3 updn match at top", per_match_o, 1);
        run(1, 2'b01);
        chk("R5 updn descending", count_o, 2);
        run(1, 2'b01);
        chk("R5 updn one", count_o, 1);
        chk("R5 no flag yet", ovf_flag_o, 0);
        run(1, 2'b01);
        chk("R5 updn zero at 2P", count_o, 0);
        chk("R5 flag at zero", ovf_flag_o, 1);
        run(1, 2'b01);
        chk("R5 updn restarts up", count_o, 1);
    endtask

    task automatic t_div();
        set_per(16'd1000);
        cfg(2'b01, 1'b0, 2'd3, 1'b0, 1'b1);
        run(7, 2'b01);
        chk("R6 div8 before tick", count_o, 0);
        run(1, 2'b01);
        chk("R6 div8 first tick", count_o, 1);
        cfg(2'b01, 1'b0, 2'd1, 1'b0, 1'b1);
        run(4, 2'b01);
        chk("R6 div2", count_o, 2);
        cfg(2'b01, 1'b0, 2'd2, 1'b0, 1'b1);
        run(8, 2'b01);
        chk("R6 div4", count_o, 2);
    endtask

    task automatic t_src();
        set_per(16'd1000);
        cfg(2'b01, 1'b1, 2'd0, 1'b0, 1'b1);
        run(5, 2'b01);
        chk("R7 unselected source ignored", count_o, 0);
        run(5, 2'b10);
        chk("R7 selected source counts", count_o, 5);
    endtask

    task automatic t_clr();
        set_per(16'd1000);
        cfg(2'b01, 1'b0, 2'd3, 1'b0, 1'b1);
        run(13, 2'b01);
        chk("R8 before clear", count_o, 1);
        @(negedge clk); clr_i = 1'b1;
        @(negedge clk); clr_i = 1'b0;
        chk("R8 count cleared", count_o, 0);
        run(7, 2'b01);
        chk("R8 divider restarted", count_o, 0);
        run(1, 2'b01);
        chk("R8 first tick after clear", count_o, 1);
    endtask

    task automatic t_hold();
        cfg(2'b10, 1'b0, 2'd0, 1'b0, 1'b1);
        run(5, 2'b01);
        cfg(2'b00, 1'b0, 2'd0, 1'b0, 1'b0);
        run(10, 2'b11);
        chk("R1 hold keeps count", count_o, 5);
    endtask

    task automatic t_irq();
        set_per(16'd1);
        cfg(2'b01, 1'b0, 2'd0, 1'b1, 1'b1);
        run(2, 2'b01);
        chk("R9 flag set", ovf_flag_o, 1);
        chk("R9 irq with enable", irq_o, 1);
        run(3, 2'b00);
        chk("R9 flag sticky", ovf_flag_o, 1);
        @(negedge clk); flag_clr_i = 1'b1;
        @(negedge clk); flag_clr_i = 1'b0;
        chk("R9 flag cleared", ovf_flag_o, 0);
        chk("R9 irq dropped", irq_o, 0);
        cfg(2'b01, 1'b0, 2'd0, 1'b0, 1'b1);
        run(2, 2'b01);
        chk("R9 flag without enable", ovf_flag_o, 1);
        chk("R9 irq masked", irq_o, 0);
    endtask

    task automatic t_setwins();
        set_per(16'd0);
        cfg(2'b01, 1'b0, 2'd0, 1'b0, 1'b1);
        run(1, 2'b01);
        chk("R10 flag set", ovf_flag_o, 1);
        @(negedge clk); src_tick_i = 2'b01; flag_clr_i = 1'b1;
        @(negedge clk); src_tick_i = 2'b00; flag_clr_i = 1'b0;
        chk("R10 set wins over clear", ovf_flag_o, 1);
        @(negedge clk); flag_clr_i = 1'b1;
        @(negedge clk); flag_clr_i = 1'b0;
        chk("R10 plain clear", ovf_flag_o, 0);
    endtask

    task automatic t_updn_pchg();
        set_per(16'd4);
        cfg(2'b11, 1'b0, 2'd0, 1'b0, 1'b1);
        run(5, 2'b01);
        chk("R11 descending", count_o, 3);
        set_per(16'd1);
        run(1, 2'b01);
        chk("R11 continues down", count_o, 2);
        run(1, 2'b01);
        chk("R11 still down", count_o, 1);
        chk("R11 no flag yet", ovf_flag_o, 0);
        run(1, 2'b01);
        chk("R11 reaches zero", count_o, 0);
        chk("R11 flag at zero", ovf_flag_o, 1);
        run(1, 2'b01);
        chk("R11 up to new P", count_o, 1);
        chk("R11 match at new P", per_match_o, 1);
    endtask

    task automatic t_up_pbelow();
        set_per(16'd10);
        cfg(2'b01, 1'b0, 2'd0, 1'b0, 1'b1);
        run(6, 2'b01);
        chk("R12 count before write", count_o, 6);
        set_per(16'd2);
        run(1, 2'b01);
        chk("R12 rolls to zero", count_o, 0);
        chk("R12 flag on roll", ovf_flag_o, 1);
    endtask

    task automatic report();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_up();
        t_free();
        t_updn();
        t_div();
        t_src();
        t_clr();
        t_hold();
        t_irq();
        t_setwins();
        t_updn_pchg();
        t_up_pbelow();
        done = 1;
        report();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            report();
        end
    end
endmodule